// File: doc/BRIEF.md
# Transparent FIFO Serial Transmitter

This block sends raw bytes from a 32-entry transmit store onto one serial data line. It adds no framing of any kind: no flag patterns, no bit stuffing and no check sequence. A host loads bytes through a write port. It then issues byte-wide commands on a command port. Bits leave the block least significant first, one bit for each cycle in which the transmit clock enable is high.

There are two transmit commands. The single-pass command sends the stored bytes once, empties the store and pulses an end-of-transmission event. The cyclic command replays the stored image without end. The read position wraps to the first byte after the last one, and no byte is consumed. Only the transmitter reset command stops the replay. That command also empties the store and forces the line to logic one. Whenever no transmission is running, the line carries ones.

Top module: `tft_tx`

## Requirements
- R1: While reset is low and in the cycle after it is released, `tx_out` is 1, `busy` is 0 and `done_evt` is 0.
- R2: The command code 0x08, accepted while idle with at least one stored byte, raises `busy` at the next clock edge. Each later edge with `bit_en` high places the next bit on `tx_out`. Bytes go out in write order, and each byte goes bit 0 first through bit 7.
- R3: In a single pass, the edge that places bit 7 of the last stored byte also drops `busy` and pulses `done_evt` high for exactly one cycle. That same edge empties the store.
- R4: The command code 0x2A, accepted under the same conditions as R2, sends the stored bytes in order. After the last bit it goes back to the first byte. It never pulses `done_evt`.
- R5: On an edge where `bit_en` is high and `busy` is low, `tx_out` becomes 1.
- R6: The command code 0x01 acts at any time. At the next edge it gives `busy` = 0 and `tx_out` = 1, empties the store and ends any transmission. A write in the same cycle is discarded.
- R7: `tx_out` changes only on an edge where `bit_en` is high or a 0x01 command is present.
- R8: A write is discarded while `busy` is high, when 32 bytes are already stored, or in the same cycle as an accepted transmit command.
- R9: Transmit commands are ignored while `busy` is high or while the store is empty. Command codes other than 0x01, 0x08 and 0x2A have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_data | input | 8 | Byte to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_data | input | 8 | Command code (0x01 reset, 0x08 single pass, 0x2A cyclic) |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| tx_out | output | 1 | Serial data line |
| busy | output | 1 | Transmission in progress; writes and start commands are refused |
| done_evt | output | 1 | One-cycle end-of-transmission event for a single pass |

## Verification
The assertions check the following on every cycle:
- After an idle enable the line is one.
- After a reset command the block is idle, the line is one and the store is empty.
- The end event coincides with the fall of `busy` and an empty store.
- The line holds steady without an enable or a reset command.
- The store level stays frozen while a transmission runs.

The bit order, the byte order and the wrap in cyclic mode can only be shown by the bench's scenarios. The same holds for the 32-byte limit, for the start command racing a write, and for code values that are ignored. The bench covers these with a reference model that compares the line, `busy` and the event every cycle.

// File: rtl/tft_pkg.sv
// Shared command codes and the sequencer mode type for the transparent
// transmitter. Assumes byte-wide commands.
package tft_pkg;
    localparam logic [7:0] CMD_RESET = 8'h01;
    localparam logic [7:0] CMD_ONCE  = 8'h08;
    localparam logic [7:0] CMD_LOOP  = 8'h2A;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_ONCE = 2'd1,
        MODE_LOOP = 2'd2
    } tx_mode_e;
endpackage

// File: rtl/tft_store.sv
// Byte store written in order from slot 0 upward and read at any slot.
// Assumes the caller has already gated push (busy, full, start). A clear
// empties the store and wins over a push in the same cycle. Slot contents
// are not reset; only the fill level is.
module tft_store #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] fill,
    output logic          full
);
    logic [W-1:0]     slot [DEPTH];
    logic [DEPTH-1:0] slot_we;

    // one write enable per slot: the slot that matches the fill level
    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign slot_we[g] = push && (fill == CW'(g));
    end

    // slot storage update
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) slot[i] <= din;
        end
    end

    // fill level tracking
    always_ff @(posedge clk) begin
        if (!rst_n)     fill <= '0;
        else if (clear) fill <= '0;
        else if (push)  fill <= fill + CW'(1);
    end

    assign full = (fill == CW'(DEPTH));
    assign dout = slot[rd_addr];
endmodule

// File: rtl/tft_cmd.sv
// Command decoder. Turns a command strobe into reset and start pulses.
// A start is accepted only while idle and with data stored. Other codes
// are dropped.
module tft_cmd #(
    parameter int CW = 6
) (
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_data,
    input  logic          busy,
    input  logic [CW-1:0] fill,
    output logic          do_reset,
    output logic          start_once,
    output logic          start_loop
);
    import tft_pkg::*;

    logic can_start;

    // decode the command byte against the current state
    always_comb begin
        can_start  = !busy && (fill != '0);
        do_reset   = cmd_valid && (cmd_data == CMD_RESET);
        start_once = cmd_valid && (cmd_data == CMD_ONCE) && can_start;
        start_loop = cmd_valid && (cmd_data == CMD_LOOP) && can_start;
    end
endmodule

// File: rtl/tft_seq.sv
// Transmit sequencer and shifter. Walks the store slot by slot and bit by
// bit, LSB first, advancing only on bit_en. Assumes the store is frozen
// while a transmission runs. Drives ones on the line when idle.
module tft_seq #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          do_reset,
    input  logic          start_once,
    input  logic          start_loop,
    input  logic [W-1:0]  rd_data,
    input  logic [CW-1:0] fill,
    output logic [AW-1:0] rd_addr,
    output logic          pass_clear,
    output logic          busy,
    output logic          tx_out,
    output logic          done_evt
);
    import tft_pkg::*;

    tx_mode_e      mode;
    logic [BW-1:0] bit_idx;
    logic [AW-1:0] rd_ptr;
    logic          last_bit;
    logic          last_slot;

    // end-of-byte and end-of-image detection
    always_comb begin
        last_bit   = (bit_idx == BW'(W - 1));
        last_slot  = ({1'b0, rd_ptr} == (fill - CW'(1)));
        pass_clear = (mode == MODE_ONCE) && bit_en && last_bit && last_slot && !do_reset;
    end

    // mode, pointers, line and event register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_IDLE;
            rd_ptr   <= '0;
            bit_idx  <= '0;
            tx_out   <= 1'b1;
            done_evt <= 1'b0;
        end else begin
            done_evt <= 1'b0;
            if (do_reset) begin
                mode    <= MODE_IDLE;
                rd_ptr  <= '0;
                bit_idx <= '0;
                tx_out  <= 1'b1;
            end else if (mode != MODE_IDLE) begin
                if (bit_en) begin
                    tx_out  <= rd_data[bit_idx];
                    bit_idx <= bit_idx + BW'(1);
                    if (last_bit) begin
                        if (!last_slot) begin
                            rd_ptr <= rd_ptr + AW'(1);
                        end else begin
                            rd_ptr <= '0;
                            if (mode == MODE_ONCE) begin
                                mode     <= MODE_IDLE;
                                done_evt <= 1'b1;
                            end
                        end
                    end
                end
            end else begin
                if (bit_en) tx_out <= 1'b1;
                rd_ptr  <= '0;
                bit_idx <= '0;
                if (start_once)      mode <= MODE_ONCE;
                else if (start_loop) mode <= MODE_LOOP;
            end
        end
    end

    assign busy    = (mode != MODE_IDLE);
    assign rd_addr = rd_ptr;
endmodule

// File: rtl/tft_tx.sv
// Top of the transparent transmitter: store, command decoder and sequencer.
// Assumes a single clock domain and that bit_en is synchronous to clk.
module tft_tx #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cmd_valid,
    input  logic [7:0]   cmd_data,
    input  logic         bit_en,
    output logic         tx_out,
    output logic         busy,
    output logic         done_evt
);
    logic          do_reset;
    logic          start_once;
    logic          start_loop;
    logic          pass_clear;
    logic          push;
    logic          full;
    logic [CW-1:0] fill;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  rd_data;

    // write gate: refused while sending, when full, or racing a command
    assign push = wr_en && !busy && !full && !start_once && !start_loop && !do_reset;

    tft_cmd #(.CW(CW)) u_cmd (
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .busy       (busy),
        .fill       (fill),
        .do_reset   (do_reset),
        .start_once (start_once),
        .start_loop (start_loop)
    );

    tft_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (do_reset || pass_clear),
        .push    (push),
        .din     (wr_data),
        .rd_addr (rd_addr),
        .dout    (rd_data),
        .fill    (fill),
        .full    (full)
    );

    tft_seq #(.W(W), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .do_reset   (do_reset),
        .start_once (start_once),
        .start_loop (start_loop),
        .rd_data    (rd_data),
        .fill       (fill),
        .rd_addr    (rd_addr),
        .pass_clear (pass_clear),
        .busy       (busy),
        .tx_out     (tx_out),
        .done_evt   (done_evt)
    );
endmodule

// File: rtl/tft_checker.sv
// Property checker for tft_tx, attached through bind. Observes ports and
// the store fill level.
module tft_checker #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_data,
    input logic          bit_en,
    input logic          tx_out,
    input logic          busy,
    input logic          done_evt,
    input logic [CW-1:0] fill
);
    logic rst_cmd;
    assign rst_cmd = cmd_valid && (cmd_data == 8'h01);

    assert_idle_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_en && !busy) |-> tx_out);

    assert_reset_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_cmd) |-> (!busy && tx_out && fill == '0));

    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> (!busy && $past(busy) && fill == '0));

    assert_line_paced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bit_en && !rst_cmd) |-> $stable(tx_out));

    assert_store_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fill));
endmodule

bind tft_tx tft_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .bit_en    (bit_en),
    .tx_out    (tx_out),
    .busy      (busy),
    .done_evt  (done_evt),
    .fill      (fill)
);

// File: tb/sim_tft_tx.sv
// Bench for tft_tx: a behavioural queue model updated on each rising edge
// and compared with the ports on each falling edge, plus scenario checks.
module sim_tft_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       bit_en = 1'b0;
    logic       tx_out;
    logic       busy;
    logic       done_evt;

    int    total = 0;
    int    bad = 0;
    int    en_period = 1;
    int    done_seen = 0;
    int    bits_seen = 0;
    bit    finished = 1'b0;
    string cur_req = "R2";

    // reference model state
    logic [7:0] q[$];
    bit  m_busy = 0, m_loop = 0, m_tx = 1, m_done = 0;
    int  m_idx = 0, m_pos = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tft_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .bit_en(bit_en),
        .tx_out(tx_out), .busy(busy), .done_evt(done_evt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic sync();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input logic [7:0] b);
        sync();
        wr_en = 1'b1;
        wr_data = b;
        sync();
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        sync();
        cmd_valid = 1'b1;
        cmd_data = c;
        sync();
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) sync();
    endtask

    // reference model: one update per rising edge
    always @(posedge clk) begin
        bit st;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_loop = 0; m_idx = 0; m_pos = 0; m_tx = 1; m_done = 0;
        end else begin
            m_done = 0;
            if (cmd_valid && cmd_data == 8'h01) begin
                q.delete();
                m_busy = 0; m_loop = 0; m_tx = 1;
            end else begin
                st = cmd_valid && !m_busy && q.size() != 0 &&
                     (cmd_data == 8'h08 || cmd_data == 8'h2A);
                if (m_busy) begin
                    if (bit_en) begin
                        m_tx = q[m_idx][m_pos];
                        m_pos++;
                        if (m_pos == 8) begin
                            m_pos = 0;
                            m_idx++;
                            if (m_idx == q.size()) begin
                                m_idx = 0;
                                if (!m_loop) begin
                                    m_busy = 0; m_done = 1; q.delete();
                                end
                            end
                        end
                    end
                end else begin
                    if (bit_en) m_tx = 1;
                    if (wr_en && q.size() < 32 && !st) q.push_back(wr_data);
                    if (st) begin
                        m_busy = 1; m_loop = (cmd_data == 8'h2A); m_idx = 0; m_pos = 0;
                    end
                end
            end
        end
    end

    // cycle compare against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(tx_out === m_tx, cur_req, "tx_out vs model", int'(tx_out), int'(m_tx));
            check(busy === m_busy, "R9", "busy vs model", int'(busy), int'(m_busy));
            check(done_evt === m_done, "R3", "done_evt vs model", int'(done_evt), int'(m_done));
            if (done_evt) done_seen++;
        end
    end

    // count bits actually shifted: enable high while busy before an edge
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n && bit_en && busy) bits_seen++;
    end

    // transmit clock enable pattern
    initial begin
        int ph = 0;
        forever begin
            sync();
            bit_en = (en_period == 1) ? 1'b1 : (ph == 0);
            ph = (ph + 1) % en_period;
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) sync();
        check(tx_out === 1'b1 && busy === 1'b0 && done_evt === 1'b0, "R1",
              "reset state tx/busy/done", int'({tx_out, busy, done_evt}), 4);
        rst_n = 1'b1;
        sync();
        check(tx_out === 1'b1 && busy === 1'b0, "R1", "after release",
              int'({tx_out, busy}), 2);

        // R2 / R3: single pass, enable every cycle
        cur_req = "R2";
        put(8'hA5); put(8'h3C); put(8'h01);
        done_seen = 0; bits_seen = 0;
        cmd(8'h08);
        check(busy === 1'b1, "R2", "busy after 0x08", int'(busy), 1);
        wait_idle(200);
        repeat (3) sync();
        check(done_seen == 1, "R3", "single pass done count", done_seen, 1);
        check(bits_seen == 24, "R2", "bits in single pass", bits_seen, 24);

        // R3 / R9: store emptied, so a new start is refused
        cmd(8'h08);
        check(busy === 1'b0, "R3", "store empty after pass", int'(busy), 0);

        // R7: sparse enable
        cur_req = "R7";
        en_period = 3;
        put(8'h96); put(8'h0F);
        done_seen = 0;
        cmd(8'h08);
        wait_idle(400);
        repeat (6) sync();
        check(done_seen == 1, "R7", "sparse pass done count", done_seen, 1);
        en_period = 1;

        // R4 / R8 / R9: cyclic replay with refused writes and commands
        cur_req = "R4";
        put(8'hC3); put(8'h5A);
        done_seen = 0;
        cmd(8'h2A);
        repeat (20) sync();
        put(8'hFF);
        cmd(8'h08);
        cmd(8'h2A);
        repeat (80) sync();
        check(busy === 1'b1, "R4", "still looping", int'(busy), 1);
        check(done_seen == 0, "R4", "no done in loop", done_seen, 0);

        // R6: reset command stops the loop
        cmd(8'h01);
        check(busy === 1'b0 && tx_out === 1'b1, "R6", "after reset cmd",
              int'({busy, tx_out}), 1);
        cmd(8'h2A);
        check(busy === 1'b0, "R6", "store cleared by reset", int'(busy), 0);

        // R6: write in the same cycle as reset is discarded
        sync();
        wr_en = 1'b1; wr_data = 8'h77; cmd_valid = 1'b1; cmd_data = 8'h01;
        sync();
        wr_en = 1'b0; cmd_valid = 1'b0;
        cmd(8'h08);
        check(busy === 1'b0, "R6", "write racing reset dropped", int'(busy), 0);

        // R9: unknown code ignored
        cur_req = "R9";
        put(8'h81);
        cmd(8'h55);
        check(busy === 1'b0, "R9", "code 0x55 ignored", int'(busy), 0);

        // R8: write racing an accepted start is dropped
        cur_req = "R8";
        bits_seen = 0;
        sync();
        wr_en = 1'b1; wr_data = 8'h22; cmd_valid = 1'b1; cmd_data = 8'h08;
        sync();
        wr_en = 1'b0; cmd_valid = 1'b0;
        wait_idle(200);
        repeat (2) sync();
        check(bits_seen == 8, "R8", "write racing start dropped", bits_seen, 8);

        // R8: 33 writes, only 32 stored
        for (int i = 0; i < 33; i++) put(8'(i * 7 + 3));
        bits_seen = 0;
        cmd(8'h08);
        wait_idle(600);
        repeat (2) sync();
        check(bits_seen == 256, "R8", "full store bit count", bits_seen, 256);

        // R5: idle ones
        cur_req = "R5";
        repeat (5) sync();
        check(tx_out === 1'b1, "R5", "idle line", int'(tx_out), 1);

        summary();
    end
endmodule